// File: doc/BRIEF.md
# Bus Ownership Drive Controller

This block sits between the internal bus engine of a processor-side bus interface and the pins of a shared external bus. It decides, cycle by cycle, whether the interface owns the bus and may drive it. It requests the bus when the engine wants to transfer. While granted it keeps the output drivers on, even when nothing is moving (bus parking). When the grant is taken away it hands the bus back cleanly. A final transfer that is already under way runs to its end first. An idle bus is released at the next clock edge.

Ownership is held in a four-state machine. S_IDLE_UNOWNED means not owner and drivers off. S_PARKED means owner with no transfer running. S_TRANSFER means an access is in progress with the grant still held. S_FINISH_LAST means the grant was lost mid-access and the final transfer is being completed. The transitions are:

- T_GAIN: S_IDLE_UNOWNED to S_PARKED when the grant is sampled high.
- T_DROP_IDLE: S_PARKED to S_IDLE_UNOWNED when the grant is sampled low.
- T_START: S_PARKED to S_TRANSFER when both the grant and the transfer request are high.
- T_DONE: S_TRANSFER or S_FINISH_LAST to S_PARKED when the transfer completes with the grant high.
- T_DONE_RELEASE: S_TRANSFER or S_FINISH_LAST to S_IDLE_UNOWNED when the transfer completes with the grant low.
- T_LOSE: S_TRANSFER to S_FINISH_LAST when the grant falls before completion.

A reset-in pin quiets the whole bus side at once, with or without a clock. Its internal use passes through a synchroniser. A reset-out pin for external devices is asserted during reset-in. It stays asserted until the clock generator reports lock again.

Top module: `bus_own_ctrl`

## Requirements
- R1: In S_PARKED, bus_driven is 1 and every bit of grp_oe is 1, whether or not a transfer is requested. In S_IDLE_UNOWNED both are 0.
- R2: If bus_grant is sampled low in S_TRANSFER while xfer_done is low, bus_driven and grp_oe stay 1 through every following cycle until xfer_done is sampled high. They go to 0 right after that edge when the grant is still low.
- R3: If bus_grant is sampled low in S_PARKED, bus_driven and all of grp_oe are 0 after that same clock edge.
- R4: bus_driven never falls at an edge at which bus_grant was sampled high. A grant that returns during S_FINISH_LAST leads to S_PARKED on completion, and driving continues.
- R5: While rst_in is 1, bus_req, bus_driven, xfer_start and all of grp_oe are 0 at once, with no clock edge needed.
- R6: rst_out is 1 whenever rst_in is 1.
- R7: After rst_in falls, rst_out stays 1 while pll_lock is low. After pll_lock is sampled high, rst_out falls at the (SYNC_STAGES+1)-th rising edge, counting the first edge that samples the high level.
- R8: xfer_start is 1 only in S_PARKED with bus_grant high and xfer_req high. A request made while the grant is low is held off: xfer_start stays 0, and it first rises in S_PARKED after the grant returns.
- R9: bus_req is 1 when xfer_req is 1 or the machine is in S_TRANSFER, and 0 otherwise.
- R10: When xfer_done is sampled high in S_TRANSFER with bus_grant high, the machine returns to S_PARKED, and bus_driven stays 1.
- R11: After rst_in falls, the bus stays undriven for SYNC_STAGES rising edges even if bus_grant is high. The grant is first acted upon at edge SYNC_STAGES+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus timing reference clock |
| rst_in | input | 1 | External reset-in, active high, asynchronous |
| pll_lock | input | 1 | Clock generator lock indication, high when locked |
| bus_grant | input | 1 | Bus grant from the external arbiter |
| xfer_req | input | 1 | Internal engine wants to start an access |
| xfer_done | input | 1 | Final transfer of the current access completes this cycle |
| bus_req | output | 1 | Bus request to the external arbiter |
| bus_driven | output | 1 | Interface is the current master and drives the bus |
| grp_oe | output | NUM_GROUPS | Output enable per pin group (address, data, attributes, strobes); 0 means three-stated |
| rst_out | output | 1 | Reset-out for external devices |
| xfer_start | output | 1 | Engine may begin its access this cycle |

## Verification
The bench builds the block with NUM_GROUPS = 4 and SYNC_STAGES = 2. The two-flop depth makes the reset release and the lock timing short enough to count edge by edge. It checks the exact edge at which reset-out falls and the exact edge at which the grant is first acted upon. Four groups let every enable bit be compared against a single expected value each cycle. With only four states and three control inputs, a few thousand random cycles visit every state under every input combination many times. A small arithmetic state model in the bench predicts each output. Directed sequences cover regrant during S_FINISH_LAST, a request held off while ungranted, and reset asserted mid-access with no clock edge.

// File: rtl/bown_pkg.sv
package bown_pkg;

    typedef enum logic [1:0] {
        S_IDLE_UNOWNED = 2'd0,
        S_PARKED       = 2'd1,
        S_TRANSFER     = 2'd2,
        S_FINISH_LAST  = 2'd3
    } own_state_e;

    // Pin groups controlled by one enable each
    localparam int GRP_ADDR   = 0;
    localparam int GRP_DATA   = 1;
    localparam int GRP_ATTR   = 2;
    localparam int GRP_STROBE = 3;
    localparam int GRP_COUNT  = 4;

endpackage

// File: rtl/bown_sync.sv
module bown_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= RESET_VAL;
                else      chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= {STAGES{RESET_VAL}};
                else      chain <= {chain[TOP-1:0], d};
            end
        end
    endgenerate

    assign q = chain[TOP];
endmodule

// File: rtl/bown_rstout.sv
module bown_rstout #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    input  logic pll_lock,
    output logic rst_out
);
    logic lock_s;
    logic hold;

    bown_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_lock_sync (
        .clk  (clk),
        .arst (rst_in),
        .d    (pll_lock),
        .q    (lock_s)
    );

    // Set by reset-in, cleared once synchronised lock is seen
    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in)      hold <= 1'b1;
        else if (lock_s) hold <= 1'b0;
    end

    assign rst_out = rst_in | hold;

    // R7: reset-out is not released while lock is still absent
    assert_rstout_waits_lock_R7: assert property (@(posedge clk) disable iff (rst_in)
        (rst_out && !lock_s) |=> rst_out);
endmodule

// File: rtl/bown_fsm.sv
module bown_fsm
    import bown_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       grant,
    input  logic       xfer_req,
    input  logic       xfer_done,
    output own_state_e state,
    output logic       drive,
    output logic       busy,
    output logic       xfer_start
);
    own_state_e next_state;

    // Next-state decode
    always_comb begin
        next_state = state;
        unique case (state)
            S_IDLE_UNOWNED: begin
                if (grant) next_state = S_PARKED;               // T_GAIN
            end
            S_PARKED: begin
                if (!grant)        next_state = S_IDLE_UNOWNED; // T_DROP_IDLE
                else if (xfer_req) next_state = S_TRANSFER;     // T_START
            end
            S_TRANSFER: begin
                if (xfer_done)  next_state = grant ? S_PARKED : S_IDLE_UNOWNED;
                else if (!grant) next_state = S_FINISH_LAST;    // T_LOSE
            end
            S_FINISH_LAST: begin
                if (xfer_done) next_state = grant ? S_PARKED : S_IDLE_UNOWNED;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= S_IDLE_UNOWNED;
        else     state <= next_state;
    end

    // Output decode
    always_comb begin
        drive      = 1'b0;
        busy       = 1'b0;
        xfer_start = 1'b0;
        unique case (state)
            S_IDLE_UNOWNED: ;
            S_PARKED: begin
                drive      = 1'b1;
                xfer_start = grant & xfer_req;
            end
            S_TRANSFER: begin
                drive = 1'b1;
                busy  = 1'b1;
            end
            S_FINISH_LAST: begin
                drive = 1'b1;
            end
        endcase
    end

    // R3: idle owner releases at the edge that sees the grant low
    assert_idle_release_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_PARKED && !grant) |=> (state == S_IDLE_UNOWNED && !drive));

    // R2: a lost grant mid-access keeps driving until completion
    assert_lose_to_finish_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_TRANSFER && !grant && !xfer_done) |=> (state == S_FINISH_LAST && drive));

    // R2: final transfer keeps the drivers on
    assert_finish_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_FINISH_LAST && !xfer_done) |=> drive);

    // R8: an accepted start always leads into a transfer
    assert_start_enters_xfer_R8: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> (state == S_TRANSFER));

    // R10: completion with grant held parks the bus
    assert_done_parks_R10: assert property (@(posedge clk) disable iff (rst)
        (state == S_TRANSFER && grant && xfer_done) |=> (state == S_PARKED && drive));
endmodule

// File: rtl/bown_oe.sv
module bown_oe #(
    parameter int NUM_GROUPS = 4
) (
    input  logic                  en,
    output logic [NUM_GROUPS-1:0] oe
);
    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            assign oe[g] = en;
        end
    endgenerate
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
    import bown_pkg::*;
#(
    parameter int NUM_GROUPS  = bown_pkg::GRP_COUNT,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_in,
    input  logic                  pll_lock,
    input  logic                  bus_grant,
    input  logic                  xfer_req,
    input  logic                  xfer_done,
    output logic                  bus_req,
    output logic                  bus_driven,
    output logic [NUM_GROUPS-1:0] grp_oe,
    output logic                  rst_out,
    output logic                  xfer_start
);
    localparam logic [NUM_GROUPS-1:0] OE_NONE = '0;

    logic       rst_sync;
    logic       rst_any;
    own_state_e state;
    logic       drive;
    logic       busy;
    logic       start_raw;
    logic       drive_ok;

    bown_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rst_sync (
        .clk  (clk),
        .arst (rst_in),
        .d    (1'b0),
        .q    (rst_sync)
    );

    // Raw pin forces quiet at once; the synchronised copy holds it
    assign rst_any = rst_in | rst_sync;

    bown_fsm u_fsm (
        .clk        (clk),
        .rst        (rst_sync),
        .grant      (bus_grant),
        .xfer_req   (xfer_req),
        .xfer_done  (xfer_done),
        .state      (state),
        .drive      (drive),
        .busy       (busy),
        .xfer_start (start_raw)
    );

    assign drive_ok   = drive & ~rst_any;
    assign bus_driven = drive_ok;
    assign bus_req    = ~rst_any & (xfer_req | busy);
    assign xfer_start = ~rst_any & start_raw;

    bown_oe #(.NUM_GROUPS(NUM_GROUPS)) u_oe (
        .en (drive_ok),
        .oe (grp_oe)
    );

    bown_rstout #(.SYNC_STAGES(SYNC_STAGES)) u_rstout (
        .clk      (clk),
        .rst_in   (rst_in),
        .pll_lock (pll_lock),
        .rst_out  (rst_out)
    );

    // R5: reset-in silences every bus-side output
    assert_reset_quiet_R5: assert property (@(posedge clk)
        rst_in |-> (!bus_req && !bus_driven && !xfer_start && grp_oe == OE_NONE));

    // R6: reset-out follows reset-in
    assert_rstout_follows_R6: assert property (@(posedge clk)
        rst_in |-> rst_out);

    // R4: bus-driven only falls after the grant has fallen
    assert_bd_needs_grant_low_R4: assert property (@(posedge clk) disable iff (rst_any)
        $fell(bus_driven) |-> !$past(bus_grant));

    // R1: group enables agree with bus-driven
    assert_oe_matches_bd_R1: assert property (@(posedge clk) disable iff (rst_any)
        bus_driven |-> (grp_oe == ~OE_NONE));

    // R11: after release the machine starts unowned
    assert_start_unowned_R11: assert property (@(posedge clk)
        $fell(rst_sync) |-> (state == S_IDLE_UNOWNED));
endmodule

// File: tb/sim_bus_own_ctrl.sv
module sim_bus_own_ctrl;
    localparam int NG = 4;
    localparam int SS = 2;

    logic          clk = 1'b0;
    logic          rst_in = 1'b1;
    logic          pll_lock = 1'b0;
    logic          bus_grant = 1'b0;
    logic          xfer_req = 1'b0;
    logic          xfer_done = 1'b0;
    logic          bus_req;
    logic          bus_driven;
    logic [NG-1:0] grp_oe;
    logic          rst_out;
    logic          xfer_start;

    int n_checks = 0;
    int n_fail   = 0;
    int st       = 0; // 0 idle, 1 parked, 2 transfer, 3 finishing
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_own_ctrl #(.NUM_GROUPS(NG), .SYNC_STAGES(SS)) u0 (
        .clk        (clk),
        .rst_in     (rst_in),
        .pll_lock   (pll_lock),
        .bus_grant  (bus_grant),
        .xfer_req   (xfer_req),
        .xfer_done  (xfer_done),
        .bus_req    (bus_req),
        .bus_driven (bus_driven),
        .grp_oe     (grp_oe),
        .rst_out    (rst_out),
        .xfer_start (xfer_start)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int next_st(int s, bit g, bit r, bit d);
        case (s)
            0:       return g ? 1 : 0;
            1:       return !g ? 0 : (r ? 2 : 1);
            2:       return d ? (g ? 1 : 0) : (g ? 2 : 3);
            default: return d ? (g ? 1 : 0) : 3;
        endcase
    endfunction

    // Drive inputs at the falling edge, check combinational outputs, advance model
    task automatic step(input bit g, input bit r, input bit d, input string tag);
        int exp_drive;
        bus_grant = g;
        xfer_req  = r;
        xfer_done = d;
        #1;
        exp_drive = (st != 0) ? 1 : 0;
        check(tag, "bus_driven", int'(bus_driven), exp_drive);
        check(tag, "grp_oe", int'(grp_oe), exp_drive * ((1 << NG) - 1));
        check("R9", "bus_req", int'(bus_req), (r || st == 2) ? 1 : 0);
        check("R8", "xfer_start", int'(xfer_start), (st == 1 && g && r) ? 1 : 0);
        @(posedge clk);
        st = next_st(st, g, r, d);
        @(negedge clk);
    endtask

    initial begin
        bus_grant = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // Reset state
        check("R5", "bus_driven", int'(bus_driven), 0);
        check("R5", "grp_oe", int'(grp_oe), 0);
        check("R5", "bus_req", int'(bus_req), 0);
        check("R6", "rst_out", int'(rst_out), 1);
        @(negedge clk);
        pll_lock = 1'b1;
        @(negedge clk);
        // Release reset with grant already high
        rst_in    = 1'b0;
        bus_grant = 1'b1;
        @(negedge clk);
        check("R11", "bus_driven e1", int'(bus_driven), 0);
        check("R7", "rst_out e1", int'(rst_out), 1);
        @(negedge clk);
        check("R11", "bus_driven e2", int'(bus_driven), 0);
        check("R7", "rst_out e2", int'(rst_out), 1);
        @(negedge clk);
        check("R11", "bus_driven e3", int'(bus_driven), 1);
        check("R7", "rst_out e3", int'(rst_out), 0);
        st = 1;

        // Parked, idle
        step(1, 0, 0, "R1");
        step(1, 0, 0, "R1");
        // Transfer finishing with grant held
        step(1, 1, 0, "R8");
        step(1, 0, 0, "R9");
        step(1, 0, 1, "R10");
        step(1, 0, 0, "R10");
        // Grant lost mid-access
        step(1, 1, 0, "R2");
        step(0, 0, 0, "R2");
        step(0, 0, 0, "R2");
        step(0, 0, 0, "R2");
        step(0, 0, 1, "R2");
        step(0, 0, 0, "R2");
        check("R2", "model idle", st, 0);
        // Request while ungranted is held off
        step(0, 1, 0, "R8");
        step(0, 1, 0, "R8");
        step(1, 1, 0, "R8");
        step(1, 1, 0, "R8");
        check("R8", "model transfer", st, 2);
        // Regrant during the final transfer
        step(0, 0, 0, "R4");
        step(1, 0, 0, "R4");
        step(1, 0, 1, "R4");
        step(1, 0, 0, "R4");
        check("R4", "model parked", st, 1);
        // Idle release
        step(0, 0, 0, "R3");
        step(0, 0, 0, "R3");
        check("R3", "model idle", st, 0);

        // Random sweep over states and input combinations
        for (int i = 0; i < 4000; i++) begin
            bit g, r, d;
            g = 1'($urandom % 2);
            r = 1'($urandom % 2);
            d = 1'($urandom % 2);
            case (st)
                0:       step(g, r, d, "R3");
                1:       step(g, r, d, "R1");
                2:       step(g, r, d, "R10");
                default: step(g, r, d, "R2");
            endcase
        end

        // Reach a transfer, then reset with no clock edge
        step(1, 0, 0, "R1");
        step(1, 1, 0, "R8");
        step(1, 0, 0, "R9");
        #2;
        rst_in   = 1'b1;
        pll_lock = 1'b0;
        #1;
        check("R5", "bus_driven async", int'(bus_driven), 0);
        check("R5", "grp_oe async", int'(grp_oe), 0);
        check("R5", "bus_req async", int'(bus_req), 0);
        check("R5", "xfer_start async", int'(xfer_start), 0);
        check("R6", "rst_out async", int'(rst_out), 1);
        @(negedge clk);
        rst_in    = 1'b0;
        bus_grant = 1'b0;
        xfer_req  = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R7", "rst_out no lock", int'(rst_out), 1);
        end
        pll_lock = 1'b1;
        @(negedge clk);
        check("R7", "rst_out l1", int'(rst_out), 1);
        @(negedge clk);
        check("R7", "rst_out l2", int'(rst_out), 1);
        @(negedge clk);
        check("R7", "rst_out l3", int'(rst_out), 0);
        st = 0;
        step(0, 0, 0, "R3");
        step(1, 0, 0, "R1");
        step(1, 0, 0, "R1");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule